// File: doc/BRIEF.md
# Configurable Match Channel Array

This block holds eight match channels, numbered 4 through 11. Each channel has a 32-bit counter, a 32-bit match value and a control word. The control word picks the counting rate from four tick-enable inputs. It also decides whether the channel compares against its own counter or against the counter that leads its group, whether a match clears the counter, and whether the channel fires again on later matches or only once. A match raises the channel's status bit when that channel's interrupt enable is high. The status bits drive one combined interrupt line.

Software reaches the registers through a single-cycle word-aligned read/write port with byte addresses. Read data appears one clock after the read strobe. Channels 9 and 11 can be set so that reading their counter also copies the counter of the channel just below them (8 or 10) into a snapshot register. The surrounding status register feeds back per-bit clear strobes.

Top module: `match_channel_array`

## Requirements
- R1: After reset every counter, match value, control word, the snapshot register and all status bits read zero, `irq` is low, and no counter advances even with all tick inputs high.
- R2: Control bits [2:0] choose the rate. Code 1 counts on `tick_in[0]`, code 2 on `tick_in[1]`, code 3 on `tick_in[2]` and code 4 on `tick_in[3]`. Codes 0, 5, 6 and 7 hold the counter. A running counter rises by one per clock on which its selected tick is high.
- R3: With control bit 7 set, a channel compares against its own counter. With bit 7 clear, channels 4–7 compare against counter 4, channels 8–9 against counter 8 and channels 10–11 against counter 10. A channel that is not one of these group leaders keeps its own counter stopped while bit 7 is clear.
- R4: A match happens on the clock where the compared counter advances to the channel's match value. On a match, status bit n−4 is set only if `irq_en[n-4]` is high.
- R5: With control bit 3 set, a match loads zero into the channel's own counter in the same clock, in place of the increment.
- R6: With control bit 6 set, the channel matches every time its compared counter reaches the match value. With bit 6 clear, it matches once and then stays quiet until its match or control register is written.
- R7: Control words of channels 4–7 keep bits [7:0] only. Those of channels 8–11 keep bits [9:0]. On channels 8–11, bit 8 set holds the channel's counter stopped.
- R8: A read of the counter of channel 9 (or 11) whose control bit 9 is set copies the current counter of channel 8 (or 10) into the snapshot register. Such a read with bit 9 clear leaves the snapshot register unchanged.
- R9: `irq` is high while any status bit is set and stays high until every status bit has been cleared through `sts_clr`.
- R10: Register map (byte address, word aligned): counter n at 0x40+4·(n−4), match n at 0x80+4·(n−4), control n at 0xC0+4·(n−4), snapshot at 0x20. A write loads the addressed register. Read data appears on the clock after the strobe. Other addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 4 | Rate tick enables for codes 1..4 |
| irq_en | input | 8 | Interrupt enable, bit k for channel k+4 |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one clock after the strobe |
| sts_clr | input | 8 | Per-channel status clear strobes |
| sts | output | 8 | Status bits of channels 4..11 |
| irq | output | 1 | Combined interrupt |

## Verification
The bench drives channel 5 from the counter of channel 4. A design that ignored group sharing would either never match or would advance the follower's own counter. It runs reset-on-match with and without periodic mode and counts the ticks between matches. A periodic design that failed to re-fire, or a one-shot design that kept firing, would leave the wrong status bit or a counter of 0 where 4 is expected. It reads counters 9 and 11 with snapshot capture on and off: a design with a wrong pairing or a missing enable check would load the snapshot register wrongly. Two status bits are cleared one at a time, so an interrupt that followed only the last set bit would drop early.

// File: rtl/mcha_pkg.sv
`timescale 1ns/1ps
package mcha_pkg;
  localparam int unsigned NCH = 8;
  localparam int unsigned CW  = 10;
  // control field positions
  localparam int unsigned C_OWN  = 7;
  localparam int unsigned C_RST  = 3;
  localparam int unsigned C_PER  = 6;
  localparam int unsigned C_HALT = 8;
  localparam int unsigned C_SNAP = 9;

  typedef enum logic [2:0] {RG_NONE, RG_CNT, RG_MAT, RG_CTL, RG_SNAP} region_e;

  // index of the counter that leads the group of channel idx (0-based)
  function automatic int unsigned grp_owner(input int unsigned idx);
    if (idx < 4) return 0;
    else if (idx < 6) return 4;
    else return 6;
  endfunction

  // rate code to tick qualifier
  function automatic logic rate_tick(input logic [2:0] sel, input logic [3:0] t);
    case (sel)
      3'd1: return t[0];
      3'd2: return t[1];
      3'd3: return t[2];
      3'd4: return t[3];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [CW-1:0] ctrl_keep(input int unsigned idx);
    return (idx < 4) ? 10'h0FF : 10'h3FF;
  endfunction
endpackage

// File: rtl/mcha_decode.sv
`timescale 1ns/1ps
module mcha_decode #(
  parameter int AW = 8,
  parameter int IW = 3
) (
  input  logic [AW-1:0]       addr,
  output mcha_pkg::region_e   rg,
  output logic [IW-1:0]       idx
);
  assign idx = addr[IW+1:2];
  always_comb begin
    rg = mcha_pkg::RG_NONE;
    if (addr[1:0] == 2'b00) begin
      case (addr[AW-1:IW+2])
        3'b001: if (idx == '0) rg = mcha_pkg::RG_SNAP;
        3'b010: rg = mcha_pkg::RG_CNT;
        3'b100: rg = mcha_pkg::RG_MAT;
        3'b110: rg = mcha_pkg::RG_CTL;
        default: rg = mcha_pkg::RG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mcha_counter.sv
`timescale 1ns/1ps
module mcha_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          zero,
  input  logic          step,
  output logic [DW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (zero)  cnt <= '0;
    else if (step)  cnt <= cnt + DW'(1);
  end
endmodule

// File: rtl/mcha_slot.sv
`timescale 1ns/1ps
module mcha_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic rearm,
  input  logic hit,
  input  logic periodic,
  input  logic en,
  input  logic clr,
  output logic armed,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b1;
      flag  <= 1'b0;
    end else begin
      if (rearm)                armed <= 1'b1;
      else if (hit && !periodic) armed <= 1'b0;
      flag <= (flag & ~clr) | (hit & en);
    end
  end
endmodule

// File: rtl/match_channel_array.sv
`timescale 1ns/1ps
module match_channel_array #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int NT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] tick_in,
  input  logic [7:0]    irq_en,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [7:0]    sts_clr,
  output logic [7:0]    sts,
  output logic          irq
);
  import mcha_pkg::*;
  localparam int NC = NCH;
  localparam int IW = $clog2(NC);

  region_e       rg;
  logic [IW-1:0] ridx;
  logic [DW-1:0] cnt [NC];
  logic [DW-1:0] mat [NC];
  logic [CW-1:0] ctl [NC];
  logic [DW-1:0] snap;
  logic [DW-1:0] rd_mux;
  logic [NC-1:0] run, hit, zap, cnt_ld, rearm, disarm, armed;
  logic          snap_take;

  mcha_decode #(.AW(AW), .IW(IW)) u_dec (.addr(bus_addr), .rg(rg), .idx(ridx));

  for (genvar g = 0; g < NC; g++) begin : g_ch
    localparam int unsigned OWN = grp_owner(g);
    logic [DW-1:0] ref_cnt;
    logic          ref_run;
    logic          ref_ld;

    assign cnt_ld[g] = bus_wr && (rg == RG_CNT) && (ridx == IW'(g));
    assign rearm[g]  = bus_wr && ((rg == RG_MAT) || (rg == RG_CTL)) && (ridx == IW'(g));
    assign run[g]    = (ctl[g][C_OWN] || (OWN == g)) && !ctl[g][C_HALT]
                       && rate_tick(ctl[g][2:0], tick_in);

    assign ref_cnt = ctl[g][C_OWN] ? cnt[g]    : cnt[OWN];
    assign ref_run = ctl[g][C_OWN] ? run[g]    : run[OWN];
    assign ref_ld  = ctl[g][C_OWN] ? cnt_ld[g] : cnt_ld[OWN];

    assign hit[g]    = armed[g] && ref_run && !ref_ld && ((ref_cnt + DW'(1)) == mat[g]);
    assign zap[g]    = hit[g] && ctl[g][C_RST];
    assign disarm[g] = hit[g] && !ctl[g][C_PER] && !rearm[g];

    mcha_counter #(.DW(DW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(cnt_ld[g]), .load_val(bus_wdata),
      .zero(zap[g]), .step(run[g]), .cnt(cnt[g])
    );

    mcha_slot u_slot (
      .clk(clk), .rst_n(rst_n), .rearm(rearm[g]), .hit(hit[g]),
      .periodic(ctl[g][C_PER]), .en(irq_en[g]), .clr(sts_clr[g]),
      .armed(armed[g]), .flag(sts[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mat[g] <= '0;
        ctl[g] <= '0;
      end else begin
        if (bus_wr && rg == RG_MAT && ridx == IW'(g)) mat[g] <= bus_wdata;
        if (bus_wr && rg == RG_CTL && ridx == IW'(g)) ctl[g] <= bus_wdata[CW-1:0] & ctrl_keep(g);
      end
    end
  end

  // reading counter 9 or 11 (index 5 or 7) may capture its lower partner
  assign snap_take = bus_rd && (rg == RG_CNT) && ridx[0] && (ridx >= IW'(5))
                     && ctl[ridx][C_SNAP];

  always_comb begin
    case (rg)
      RG_CNT:  rd_mux = cnt[ridx];
      RG_MAT:  rd_mux = mat[ridx];
      RG_CTL:  rd_mux = DW'(ctl[ridx]);
      RG_SNAP: rd_mux = snap;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap      <= '0;
      bus_rdata <= '0;
    end else begin
      if (snap_take) snap <= cnt[ridx - IW'(1)];
      bus_rdata <= bus_rd ? rd_mux : '0;
    end
  end

  assign irq = |sts;
endmodule

// File: rtl/mcha_check.sv
`timescale 1ns/1ps
module mcha_check #(
  parameter int NC = 8,
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic [NC-1:0] sts,
  input logic [NC-1:0] sts_clr,
  input logic [NC-1:0] irq_en,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic [NC-1:0] hit,
  input logic [NC-1:0] disarm
);
  // R4: a status bit only rises for an enabled channel
  p_enable_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & ~$past(sts) & ~$past(irq_en)) == '0));

  // R9: status stays nonzero while an unclear bit remains
  p_sticky_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & ~sts_clr) != '0) |=> (sts != '0));

  // R9: the interrupt only drops after a clear strobe
  p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(sts_clr != '0));

  // R7: control words of channels 4..7 read back no higher bits
  p_narrow_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_rd) && ($past(bus_addr[7:4]) == 4'hC)) |-> (bus_rdata[DW-1:8] == '0));

  // R10: addresses below the snapshot register read zero
  p_hole_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_rd) && ($past(bus_addr[7:5]) == 3'b000)) |-> (bus_rdata == '0));

  // R6: a one-shot channel cannot match on the very next clock
  p_oneshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (disarm != '0) |=> ((hit & $past(disarm)) == '0));
endmodule

bind match_channel_array mcha_check #(.NC(8), .DW(DW), .AW(AW)) u_mcha_check (
  .clk(clk), .rst_n(rst_n), .irq(irq), .sts(sts), .sts_clr(sts_clr),
  .irq_en(irq_en), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .hit(hit), .disarm(disarm)
);

// File: tb/test_match_channel_array.sv
`timescale 1ns/1ps
module test_match_channel_array;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tick_in = '0;
  logic [7:0]  irq_en = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  sts_clr = '0;
  logic [7:0]  sts;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] v;

  always #10 clk = ~clk;

  match_channel_array i_match_channel_array (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .irq_en(irq_en),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sts_clr(sts_clr), .sts(sts), .irq(irq)
  );

  // {address, write data, expected readback}
  localparam int NV = 9;
  localparam logic [71:0] TBL [NV] = '{
    {8'hC0, 32'h0000_03FF, 32'h0000_00FF},   // R7 ch4 narrow
    {8'hCC, 32'h0000_03FF, 32'h0000_00FF},   // R7 ch7 narrow
    {8'hD0, 32'h0000_03FF, 32'h0000_03FF},   // R7 ch8 wide
    {8'hDC, 32'hFFFF_FFFF, 32'h0000_03FF},   // R7 ch11 wide
    {8'h80, 32'hDEAD_BEEF, 32'hDEAD_BEEF},   // R10 match 4
    {8'h9C, 32'h1234_5678, 32'h1234_5678},   // R10 match 11
    {8'h44, 32'h0000_ABCD, 32'h0000_ABCD},   // R10 counter load
    {8'h00, 32'hFFFF_FFFF, 32'h0000_0000},   // R10 hole
    {8'h60, 32'hFFFF_FFFF, 32'h0000_0000}    // R10 hole
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic ticks(input logic [3:0] t, input int n);
    @(negedge clk); tick_in = t;
    repeat (n) @(negedge clk);
    tick_in = '0;
  endtask

  task automatic clr(input logic [7:0] m);
    @(negedge clk); sts_clr = m;
    @(negedge clk); sts_clr = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    // table walk: write then read back
    for (int i = 0; i < NV; i++) begin
      wr(TBL[i][71:64], TBL[i][63:32]);
      rd(TBL[i][71:64], v);
      chk($sformatf("R7/R10 table %0d", i), v, TBL[i][31:0]);
    end

    do_reset();
    // R1 reset state
    rd(8'h40, v); chk("R1 cnt4", v, 0);
    rd(8'hD0, v); chk("R1 ctl8", v, 0);
    rd(8'h9C, v); chk("R1 mat11", v, 0);
    rd(8'h20, v); chk("R1 snap", v, 0);
    chk("R1 sts", {24'd0, sts}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    ticks(4'hF, 5);
    rd(8'h40, v); chk("R1 stopped", v, 0);

    irq_en = 8'hFF;
    // R2 rate selection
    wr(8'hC0, 32'h1);
    ticks(4'b0010, 5); rd(8'h40, v); chk("R2 wrong tick", v, 0);
    ticks(4'b0001, 5); rd(8'h40, v); chk("R2 code1", v, 5);
    wr(8'hC0, 32'h4);
    ticks(4'b1000, 3); rd(8'h40, v); chk("R2 code4", v, 8);
    wr(8'hC0, 32'h5);
    ticks(4'hF, 4);    rd(8'h40, v); chk("R2 code5 stopped", v, 8);

    // R3 sharing: ch5 follows counter 4
    wr(8'hC0, 32'h1); wr(8'h40, 32'h0);
    wr(8'h84, 32'd6); wr(8'hC4, 32'h01);
    ticks(4'b0001, 6);
    chk("R3/R4 shared match sts", {24'd0, sts}, 32'h02);
    chk("R9 irq up", {31'd0, irq}, 1);
    rd(8'h44, v); chk("R3 follower cnt stopped", v, 0);
    rd(8'h40, v); chk("R3 leader cnt", v, 6);
    clr(8'h02);
    chk("R9 irq down", {31'd0, irq}, 0);
    // R3 own counter
    wr(8'hC4, 32'h81);
    ticks(4'b0001, 3); rd(8'h44, v); chk("R3 own counting", v, 3);
    chk("R3 no early match", {24'd0, sts}, 0);
    ticks(4'b0001, 3);
    chk("R3 own match", {24'd0, sts}, 32'h02);
    clr(8'h02);
    wr(8'hC0, 32'h0); wr(8'hC4, 32'h0);

    // R4 enable gating on ch8
    irq_en = 8'hEF;
    wr(8'h50, 32'h0); wr(8'h90, 32'd3); wr(8'hD0, 32'h01);
    ticks(4'b0001, 3);
    chk("R4 disabled no status", {24'd0, sts}, 0);
    rd(8'h50, v); chk("R4 counter reached", v, 3);
    irq_en = 8'hFF;

    // R5/R6 reset-on-match, periodic
    wr(8'hD0, 32'h0); wr(8'h50, 32'h0); wr(8'h90, 32'd4); wr(8'hD0, 32'h49);
    ticks(4'b0001, 4);
    chk("R5 match status", {24'd0, sts}, 32'h10);
    rd(8'h50, v); chk("R5 counter zeroed", v, 0);
    clr(8'h10);
    ticks(4'b0001, 4);
    chk("R6 periodic again", {24'd0, sts}, 32'h10);
    clr(8'h10);
    // one-shot
    wr(8'hD0, 32'h09);
    ticks(4'b0001, 4);
    chk("R6 one-shot first", {24'd0, sts}, 32'h10);
    clr(8'h10);
    ticks(4'b0001, 4);
    chk("R6 one-shot silent", {24'd0, sts}, 0);
    rd(8'h50, v); chk("R6 one-shot no reset", v, 4);

    // R7 halt bit on ch9
    wr(8'hD0, 32'h0);
    wr(8'hD4, 32'h181);
    ticks(4'b0001, 5); rd(8'h54, v); chk("R7 halted", v, 0);
    wr(8'hD4, 32'h81);
    ticks(4'b0001, 2); rd(8'h54, v); chk("R7 released", v, 2);

    // R8 snapshot
    wr(8'h50, 32'h1234); wr(8'hD4, 32'h200);
    rd(8'h54, v); chk("R8 cnt9 read", v, 2);
    rd(8'h20, v); chk("R8 snap from cnt8", v, 32'h1234);
    wr(8'hDC, 32'h0); wr(8'h58, 32'h55);
    rd(8'h5C, v); rd(8'h20, v); chk("R8 disabled keeps snap", v, 32'h1234);
    wr(8'hDC, 32'h200);
    rd(8'h5C, v); rd(8'h20, v); chk("R8 snap from cnt10", v, 32'h55);

    // R9 combined interrupt with two sources
    wr(8'h90, 32'd3); wr(8'h94, 32'd3);
    wr(8'h50, 32'h0); wr(8'hD0, 32'h01); wr(8'hD4, 32'h00);
    ticks(4'b0001, 3);
    chk("R9 two status", {24'd0, sts}, 32'h30);
    clr(8'h10);
    chk("R9 irq held", {31'd0, irq}, 1);
    chk("R9 one left", {24'd0, sts}, 32'h20);
    clr(8'h20);
    chk("R9 irq released", {31'd0, irq}, 0);

    finish_run();
  end
endmodule